// File: doc/BRIEF.md
# BCD Clock and Calendar Core

This block keeps time of day and the calendar in packed BCD. A single-cycle enable, `tick_32k`, marks each period of a 32.768 kHz reference. A fractional divider turns those ticks into exactly one hundred steps per second. Every step advances a cascade of nine byte registers, one per time or date field. The cascade runs from hundredths of a second up to the century, with the month length chosen from the month and the year.

The host reaches the registers through a byte port. A pulse on `addr_load` sets the byte pointer, and the same pulse freezes a shadow copy of all nine bytes. Reads return bytes from that copy, so a carry that ripples during a read cannot tear the value. Each read or write strobe moves the pointer on by one. Written bytes are held as pending and replace the live fields on the next hundredths step. Writing the seconds byte also clears the divider, so the next step comes a known number of ticks later.

The byte map is fixed. Byte 0 holds the hundredths, byte 1 the seconds, byte 2 the minutes and byte 3 the hours. Byte 4 holds the weekday, byte 5 the day of month, byte 6 the month, byte 7 the year and byte 8 the century.

Top module: `rtc_bcd_calendar`

## Requirements
- R1: While `rst_n` is low at a clock edge, the nine bytes reset to 00,00,00,00,01,01,01,00,00 for bytes 0 to 8. This means 00:00:00.00, weekday 1, day 01, month 01, year 00 and century 00.
- R2: The divider adds 100 for each cycle with `tick_32k` high and makes a step whenever the sum reaches 32768, then keeps the remainder. From a cleared divider the first step comes on the 328th tick, and 32768 ticks give exactly 100 steps. Two steps never occur on adjacent cycles.
- R3: Each field advances one BCD digit pair at a time. The low nibble wraps from 9 to 0 and carries into the high nibble.
- R4: Hundredths wrap from 99 to 00, seconds and minutes from 59 to 00, and hours from 23 to 00. Each wrap carries into the next field.
- R5: When the hours wrap, a day of month equal to the month's last day becomes 01 and the month advances. The same carry moves the weekday on, and the weekday wraps from 7 to 1.
- R6: Months 04, 06, 09 and 11 have 30 days. Month 02 has 28 or 29 days. Every other month has 31 days.
- R7: Month 02 has 29 days when the year's binary value is divisible by four, year 00 included.
- R8: The month wraps from 12 to 01 and carries into the year. The year wraps from 99 to 00 and carries into the century, and the century wraps from 99 to 00.
- R9: `addr_load` sets the pointer to `addr_in`, and a value above 8 selects 0. Each cycle with `rd_en` or `wr_en` high and `addr_load` low advances the pointer, and the pointer wraps from 8 to 0. When `addr_load` is high, the strobes in that cycle are ignored.
- R10: `addr_load` copies all nine live bytes into the shadow. `rd_data` always shows the shadow byte at the pointer, and later counting does not change it.
- R11: A written byte is held and loaded on the next step. On that step no field increments. A write to byte 1 clears the divider, so the load comes on the 328th following tick.
- R12: The time registers change only on a step. Cycles without `tick_32k` leave them unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick_32k | input | 1 | One-cycle enable per 32.768 kHz period |
| addr_load | input | 1 | Load the pointer and take a shadow copy |
| addr_in | input | 4 | Start byte index, 0 to 8 |
| wr_en | input | 1 | Write `wr_data` at the pointer, then advance |
| wr_data | input | 8 | BCD byte to write |
| rd_en | input | 1 | Advance the pointer after a read |
| rd_data | output | 8 | Shadow byte at the pointer |

## Verification
The bound checker watches several rules on every cycle. It checks that steps are never adjacent and that the time registers and the shadow stay stable when nothing triggers them. It also checks the pointer's advance and wrap, the divider clearing after a seconds write, and the hundredths wrap. Only the bench's scenarios can show the calendar arithmetic: the month lengths, the leap years, the weekday and century carries, and the exact tick count to the first step after a write. The same holds for the tear-free snapshot.

// File: rtl/rtc_cal_pkg.sv
// Package: shared constants, byte indices and BCD helpers for the clock core.
// Assumes all stored values are valid packed BCD.
package rtc_cal_pkg;

    localparam int NUM_REGS = 9;
    localparam int ADDR_W   = 4;

    typedef enum logic [ADDR_W-1:0] {
        IDX_HUND  = 4'd0,
        IDX_SEC   = 4'd1,
        IDX_MIN   = 4'd2,
        IDX_HOUR  = 4'd3,
        IDX_DAY   = 4'd4,
        IDX_DATE  = 4'd5,
        IDX_MONTH = 4'd6,
        IDX_YEAR  = 4'd7,
        IDX_CENT  = 4'd8
    } reg_idx_e;

    typedef logic [NUM_REGS-1:0][7:0] time_vec_t;

    // Advance a two-digit BCD value by one, with a per-nibble wrap.
    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        logic [3:0] lo;
        logic [3:0] hi;
        lo = v[3:0];
        hi = v[7:4];
        if (lo >= 4'd9) begin
            lo = 4'd0;
            hi = (hi >= 4'd9) ? 4'd0 : hi + 4'd1;
        end else begin
            lo = lo + 4'd1;
        end
        return {hi, lo};
    endfunction

    // Convert two BCD digits to binary.
    function automatic logic [6:0] bcd_to_bin(input logic [7:0] v);
        return 7'(v[7:4]) * 7'd10 + 7'(v[3:0]);
    endfunction

    // Leap test: divisible-by-four rule only.
    function automatic logic is_leap(input logic [7:0] year);
        return (bcd_to_bin(year) % 7'd4) == 7'd0;
    endfunction

    // Last day of a month, in BCD.
    function automatic logic [7:0] month_last(input logic [7:0] month, input logic [7:0] year);
        case (month)
            8'h02:                      return is_leap(year) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

    // Reset and wrap value of each field.
    function automatic logic [7:0] base_val(input int idx);
        if (idx == int'(IDX_DAY) || idx == int'(IDX_DATE) || idx == int'(IDX_MONTH))
            return 8'h01;
        return 8'h00;
    endfunction

endpackage

// File: rtl/rtc_frac_div.sv
// Fractional divider: adds STEP_HZ per input tick and makes a step each time
// the sum reaches SRC_HZ, keeping the remainder so that no error accumulates.
// Assumes STEP_HZ < SRC_HZ. A clear has priority and suppresses the step.
module rtc_frac_div #(
    parameter int SRC_HZ  = 32768,
    parameter int STEP_HZ = 100,
    localparam int ACC_W  = $clog2(SRC_HZ + STEP_HZ)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_in,
    input  logic             clr,
    output logic             step,
    output logic [ACC_W-1:0] acc_o
);
    localparam logic [ACC_W:0] INC = (ACC_W+1)'(STEP_HZ);
    localparam logic [ACC_W:0] LIM = (ACC_W+1)'(SRC_HZ);

    logic [ACC_W-1:0] acc;
    logic [ACC_W:0]   sum;

    // Next accumulator sum and the step decision.
    always_comb begin
        sum  = {1'b0, acc} + INC;
        step = tick_in && !clr && (sum >= LIM);
    end

    // Accumulator register.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            acc <= '0;
        else if (tick_in)
            acc <= step ? ACC_W'(sum - LIM) : ACC_W'(sum);
    end

    assign acc_o = acc;
endmodule

// File: rtl/rtc_time_chain.sv
// Time chain: nine BCD field registers. On a step it either loads the pending
// host bytes (no increment that step) or runs the carry cascade.
// Assumes fields hold valid BCD; a day of month above the month's last day also wraps.
module rtc_time_chain
    import rtc_cal_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                step,
    input  logic [NUM_REGS-1:0] load_mask,
    input  time_vec_t           load_val,
    output time_vec_t           time_q
);
    time_vec_t nxt;

    // Next value of every field: a load or the rollover cascade.
    always_comb begin
        logic       carry;
        logic [7:0] lim;
        nxt   = time_q;
        carry = 1'b1;
        if (step) begin
            if (|load_mask) begin
                for (int i = 0; i < NUM_REGS; i++)
                    if (load_mask[i]) nxt[i] = load_val[i];
            end else begin
                for (int i = 0; i < NUM_REGS; i++) begin
                    if (i == int'(IDX_DAY)) continue;
                    if (i == int'(IDX_DATE) && carry)
                        nxt[IDX_DAY] = (time_q[IDX_DAY] >= 8'h07) ? 8'h01 : bcd_inc(time_q[IDX_DAY]);
                    case (i)
                        int'(IDX_HUND), int'(IDX_YEAR), int'(IDX_CENT): lim = 8'h99;
                        int'(IDX_SEC), int'(IDX_MIN):                   lim = 8'h59;
                        int'(IDX_HOUR):                                 lim = 8'h23;
                        int'(IDX_DATE):  lim = month_last(time_q[IDX_MONTH], time_q[IDX_YEAR]);
                        default:                                        lim = 8'h12;
                    endcase
                    if (carry) begin
                        if (time_q[i] >= lim) begin
                            nxt[i] = base_val(i);
                        end else begin
                            nxt[i] = bcd_inc(time_q[i]);
                            carry  = 1'b0;
                        end
                    end
                end
            end
        end
    end

    // One register per field, each with its own reset value.
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_field
        always_ff @(posedge clk) begin
            if (!rst_n) time_q[g] <= base_val(g);
            else        time_q[g] <= nxt[g];
        end
    end
endmodule

// File: rtl/rtc_host_port.sv
// Host port: byte pointer with auto-increment, a shadow snapshot taken on a
// pointer load, and pending write bytes released on the next step.
// Assumes addr_load has priority over the read and write strobes.
module rtc_host_port
    import rtc_cal_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                addr_load,
    input  logic [ADDR_W-1:0]   addr_in,
    input  logic                rd_en,
    input  logic                wr_en,
    input  logic [7:0]          wr_data,
    input  logic                step,
    input  time_vec_t           time_q,
    output logic [7:0]          rd_data,
    output logic [NUM_REGS-1:0] pend_mask,
    output time_vec_t           pend_val,
    output logic                sec_wr,
    output logic [ADDR_W-1:0]   ptr,
    output time_vec_t           shadow
);
    localparam logic [ADDR_W-1:0] LAST = ADDR_W'(NUM_REGS - 1);

    logic wr_hit;

    // Decode a write that takes effect this cycle.
    always_comb begin
        wr_hit = wr_en && !addr_load;
        sec_wr = wr_hit && (ptr == IDX_SEC);
    end

    // Byte pointer: load, or advance with a wrap.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr <= '0;
        else if (addr_load)
            ptr <= (addr_in > LAST) ? '0 : addr_in;
        else if (rd_en || wr_en)
            ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
    end

    // Shadow snapshot for reads.
    always_ff @(posedge clk) begin
        if (!rst_n)         shadow <= '0;
        else if (addr_load) shadow <= time_q;
    end

    // Pending bytes: set by a write, cleared by the step that loads them.
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_pend
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pend_mask[g] <= 1'b0;
                pend_val[g]  <= '0;
            end else if (wr_hit && ptr == ADDR_W'(g)) begin
                pend_mask[g] <= 1'b1;
                pend_val[g]  <= wr_data;
            end else if (step) begin
                pend_mask[g] <= 1'b0;
            end
        end
    end

    assign rd_data = shadow[ptr];
endmodule

// File: rtl/rtc_bcd_calendar.sv
// Top: BCD clock and calendar core. Connects the divider, the time chain and
// the host port. Assumes tick_32k is a one-cycle enable per reference period.
module rtc_bcd_calendar
    import rtc_cal_pkg::*;
#(
    parameter int SRC_HZ  = 32768,
    parameter int STEP_HZ = 100,
    localparam int ACC_W  = $clog2(SRC_HZ + STEP_HZ)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_32k,
    input  logic              addr_load,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              wr_en,
    input  logic [7:0]        wr_data,
    input  logic              rd_en,
    output logic [7:0]        rd_data
);
    logic                step;
    logic                sec_wr;
    logic                pend_any;
    logic [ACC_W-1:0]    div_acc;
    logic [NUM_REGS-1:0] pend_mask;
    logic [ADDR_W-1:0]   ptr;
    time_vec_t           pend_val;
    time_vec_t           time_q;
    time_vec_t           shadow;

    assign pend_any = |pend_mask;

    rtc_frac_div #(.SRC_HZ(SRC_HZ), .STEP_HZ(STEP_HZ)) u_div (
        .clk(clk), .rst_n(rst_n), .tick_in(tick_32k), .clr(sec_wr),
        .step(step), .acc_o(div_acc)
    );

    rtc_time_chain u_chain (
        .clk(clk), .rst_n(rst_n), .step(step),
        .load_mask(pend_mask), .load_val(pend_val), .time_q(time_q)
    );

    rtc_host_port u_port (
        .clk(clk), .rst_n(rst_n), .addr_load(addr_load), .addr_in(addr_in),
        .rd_en(rd_en), .wr_en(wr_en), .wr_data(wr_data), .step(step),
        .time_q(time_q), .rd_data(rd_data), .pend_mask(pend_mask),
        .pend_val(pend_val), .sec_wr(sec_wr), .ptr(ptr), .shadow(shadow)
    );
endmodule

// File: rtl/rtc_bcd_calendar_chk.sv
// Checker: cycle-level properties of the clock core, bound to the top module.
module rtc_bcd_calendar_chk
    import rtc_cal_pkg::*;
#(
    parameter int ACC_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              step,
    input logic              pend_any,
    input logic              sec_wr,
    input logic              addr_load,
    input logic              rd_en,
    input logic              wr_en,
    input logic [ADDR_W-1:0] ptr,
    input logic [ACC_W-1:0]  div_acc,
    input time_vec_t         time_q,
    input time_vec_t         shadow
);
    AST_STEP_SPACING: assert property (@(posedge clk) disable iff (!rst_n) step |=> !step); // R2
    AST_REGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !step |=> $stable(time_q)); // R12
    AST_SNAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !addr_load |=> $stable(shadow)); // R10
    AST_PTR_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_en || wr_en) && !addr_load && ptr != 4'd8) |=> ptr == $past(ptr) + 4'd1); // R9
    AST_PTR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_en || wr_en) && !addr_load && ptr == 4'd8) |=> ptr == 4'd0); // R9
    AST_DIV_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) sec_wr |=> div_acc == '0); // R11
    AST_HUND_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !pend_any && time_q[IDX_HUND] == 8'h99) |=> time_q[IDX_HUND] == 8'h00); // R4
endmodule

bind rtc_bcd_calendar rtc_bcd_calendar_chk #(.ACC_W(ACC_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .step(step), .pend_any(pend_any), .sec_wr(sec_wr),
    .addr_load(addr_load), .rd_en(rd_en), .wr_en(wr_en), .ptr(ptr),
    .div_acc(div_acc), .time_q(time_q), .shadow(shadow)
);

// File: tb/rtc_bcd_calendar_bench.sv
// Directed bench: one task per scenario, each checking its own results.
module rtc_bcd_calendar_bench;
    import rtc_cal_pkg::*;

    typedef logic [7:0] frame_t [NUM_REGS];

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_32k = 1'b0;
    logic       addr_load = 1'b0;
    logic [3:0] addr_in = '0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       rd_en = 1'b0;
    logic [7:0] rd_data;
    int         n_chk = 0;
    int         n_fail = 0;

    always #2 clk = ~clk;

    rtc_bcd_calendar u_rtc_bcd_calendar (
        .clk(clk), .rst_n(rst_n), .tick_32k(tick_32k), .addr_load(addr_load),
        .addr_in(addr_in), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
        .rd_data(rd_data)
    );

    task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic run_ticks(input int n);
        @(negedge clk) tick_32k = 1'b1;
        repeat (n) @(negedge clk);
        tick_32k = 1'b0;
    endtask

    task automatic set_addr(input logic [3:0] a);
        @(negedge clk);
        addr_load = 1'b1;
        addr_in   = a;
        @(negedge clk);
        addr_load = 1'b0;
    endtask

    task automatic read_cont(input int n, output frame_t got);
        got = '{default: 8'h00};
        rd_en = 1'b1;
        for (int i = 0; i < n; i++) begin
            got[i] = rd_data;
            @(negedge clk);
        end
        rd_en = 1'b0;
    endtask

    task automatic read_from(input logic [3:0] a, input int n, output frame_t got);
        set_addr(a);
        read_cont(n, got);
    endtask

    task automatic check_frame(input string tag, input frame_t exp);
        frame_t got;
        read_from(4'd0, NUM_REGS, got);
        for (int i = 0; i < NUM_REGS; i++)
            check8($sformatf("%s byte %0d", tag, i), got[i], exp[i]);
    endtask

    task automatic write_frame(input frame_t v);
        set_addr(4'd0);
        wr_en = 1'b1;
        for (int i = 0; i < NUM_REGS; i++) begin
            wr_data = v[i];
            @(negedge clk);
        end
        wr_en = 1'b0;
    endtask

    // Load a start frame, then one step later compare with the expected frame.
    task automatic roll_case(input string tag, input frame_t start, input frame_t exp);
        write_frame(start);
        run_ticks(328);
        check_frame({tag, " loaded"}, start);
        run_ticks(328);
        check_frame(tag, exp);
    endtask

    task automatic t_reset;
        check_frame("R1 reset", '{8'h00, 8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00});
    endtask

    task automatic t_divider;
        frame_t got;
        run_ticks(327);
        read_from(4'd0, 1, got);
        check8("R2 no step before tick 328", got[0], 8'h00);
        run_ticks(1);
        read_from(4'd0, 1, got);
        check8("R2 first step on tick 328", got[0], 8'h01);
        run_ticks(32439);
        read_from(4'd0, 2, got);
        check8("R2 32767 ticks hundredths", got[0], 8'h99);
        check8("R2 32767 ticks seconds", got[1], 8'h00);
        run_ticks(1);
        read_from(4'd0, 2, got);
        check8("R2 32768 ticks hundredths", got[0], 8'h00);
        check8("R2 32768 ticks seconds", got[1], 8'h01);
    endtask

    task automatic t_idle_hold;
        repeat (500) @(negedge clk);
        check_frame("R12 idle hold", '{8'h00, 8'h01, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00});
    endtask

    task automatic t_write_timing;
        write_frame('{8'h12, 8'h34, 8'h56, 8'h07, 8'h03, 8'h15, 8'h08, 8'h26, 8'h20});
        run_ticks(327);
        check_frame("R11 not loaded before step", '{8'h00, 8'h01, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00});
        run_ticks(1);
        check_frame("R11 loaded on step", '{8'h12, 8'h34, 8'h56, 8'h07, 8'h03, 8'h15, 8'h08, 8'h26, 8'h20});
        run_ticks(328);
        check_frame("R11 counts after load", '{8'h13, 8'h34, 8'h56, 8'h07, 8'h03, 8'h15, 8'h08, 8'h26, 8'h20});
    endtask

    task automatic t_digit_carry;
        roll_case("R3 low nibble carry", '{8'h09, 8'h29, 8'h19, 8'h09, 8'h02, 8'h09, 8'h09, 8'h19, 8'h20},
                                         '{8'h10, 8'h29, 8'h19, 8'h09, 8'h02, 8'h09, 8'h09, 8'h19, 8'h20});
        roll_case("R3 carry into seconds", '{8'h99, 8'h09, 8'h19, 8'h09, 8'h02, 8'h09, 8'h09, 8'h19, 8'h20},
                                           '{8'h00, 8'h10, 8'h19, 8'h09, 8'h02, 8'h09, 8'h09, 8'h19, 8'h20});
    endtask

    task automatic t_time_roll;
        roll_case("R4 to hour 23", '{8'h99, 8'h59, 8'h59, 8'h22, 8'h05, 8'h10, 8'h03, 8'h30, 8'h20},
                                   '{8'h00, 8'h00, 8'h00, 8'h23, 8'h05, 8'h10, 8'h03, 8'h30, 8'h20});
    endtask

    task automatic t_month_len;
        roll_case("R5 R6 April 30", '{8'h99, 8'h59, 8'h59, 8'h23, 8'h03, 8'h30, 8'h04, 8'h21, 8'h20},
                                    '{8'h00, 8'h00, 8'h00, 8'h00, 8'h04, 8'h01, 8'h05, 8'h21, 8'h20});
        roll_case("R6 January 30", '{8'h99, 8'h59, 8'h59, 8'h23, 8'h02, 8'h30, 8'h01, 8'h21, 8'h20},
                                   '{8'h00, 8'h00, 8'h00, 8'h00, 8'h03, 8'h31, 8'h01, 8'h21, 8'h20});
        roll_case("R5 weekday wrap Jan 31", '{8'h99, 8'h59, 8'h59, 8'h23, 8'h07, 8'h31, 8'h01, 8'h21, 8'h20},
                                            '{8'h00, 8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h02, 8'h21, 8'h20});
        roll_case("R6 November 30", '{8'h99, 8'h59, 8'h59, 8'h23, 8'h04, 8'h30, 8'h11, 8'h21, 8'h20},
                                    '{8'h00, 8'h00, 8'h00, 8'h00, 8'h05, 8'h01, 8'h12, 8'h21, 8'h20});
        roll_case("R6 August 31", '{8'h99, 8'h59, 8'h59, 8'h23, 8'h04, 8'h31, 8'h08, 8'h21, 8'h20},
                                  '{8'h00, 8'h00, 8'h00, 8'h00, 8'h05, 8'h01, 8'h09, 8'h21, 8'h20});
    endtask

    task automatic t_leap;
        roll_case("R7 Feb 28 year 24", '{8'h99, 8'h59, 8'h59, 8'h23, 8'h03, 8'h28, 8'h02, 8'h24, 8'h20},
                                       '{8'h00, 8'h00, 8'h00, 8'h00, 8'h04, 8'h29, 8'h02, 8'h24, 8'h20});
        roll_case("R7 Feb 29 year 24", '{8'h99, 8'h59, 8'h59, 8'h23, 8'h04, 8'h29, 8'h02, 8'h24, 8'h20},
                                       '{8'h00, 8'h00, 8'h00, 8'h00, 8'h05, 8'h01, 8'h03, 8'h24, 8'h20});
        roll_case("R7 Feb 28 year 23", '{8'h99, 8'h59, 8'h59, 8'h23, 8'h02, 8'h28, 8'h02, 8'h23, 8'h20},
                                       '{8'h00, 8'h00, 8'h00, 8'h00, 8'h03, 8'h01, 8'h03, 8'h23, 8'h20});
        roll_case("R7 Feb 28 year 00", '{8'h99, 8'h59, 8'h59, 8'h23, 8'h02, 8'h28, 8'h02, 8'h00, 8'h21},
                                       '{8'h00, 8'h00, 8'h00, 8'h00, 8'h03, 8'h29, 8'h02, 8'h00, 8'h21});
        roll_case("R7 Feb 28 year 12", '{8'h99, 8'h59, 8'h59, 8'h23, 8'h02, 8'h28, 8'h02, 8'h12, 8'h20},
                                       '{8'h00, 8'h00, 8'h00, 8'h00, 8'h03, 8'h29, 8'h02, 8'h12, 8'h20});
        roll_case("R7 Feb 28 year 26", '{8'h99, 8'h59, 8'h59, 8'h23, 8'h02, 8'h28, 8'h02, 8'h26, 8'h20},
                                       '{8'h00, 8'h00, 8'h00, 8'h00, 8'h03, 8'h01, 8'h03, 8'h26, 8'h20});
    endtask

    task automatic t_year;
        roll_case("R8 new year", '{8'h99, 8'h59, 8'h59, 8'h23, 8'h06, 8'h31, 8'h12, 8'h45, 8'h20},
                                 '{8'h00, 8'h00, 8'h00, 8'h00, 8'h07, 8'h01, 8'h01, 8'h46, 8'h20});
        roll_case("R8 new century", '{8'h99, 8'h59, 8'h59, 8'h23, 8'h07, 8'h31, 8'h12, 8'h99, 8'h20},
                                    '{8'h00, 8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h21});
        roll_case("R8 century wrap", '{8'h99, 8'h59, 8'h59, 8'h23, 8'h05, 8'h31, 8'h12, 8'h99, 8'h99},
                                     '{8'h00, 8'h00, 8'h00, 8'h00, 8'h06, 8'h01, 8'h01, 8'h00, 8'h00});
    endtask

    task automatic t_address;
        frame_t got;
        write_frame('{8'h11, 8'h22, 8'h33, 8'h14, 8'h05, 8'h16, 8'h07, 8'h18, 8'h19});
        run_ticks(328);
        read_from(4'd6, 5, got);
        check8("R9 start at month", got[0], 8'h07);
        check8("R9 increment to year", got[1], 8'h18);
        check8("R9 increment to century", got[2], 8'h19);
        check8("R9 wrap to hundredths", got[3], 8'h11);
        check8("R9 wrap then seconds", got[4], 8'h22);
        read_from(4'd12, 1, got);
        check8("R9 out of range start", got[0], 8'h11);
    endtask

    task automatic t_snapshot;
        frame_t got;
        write_frame('{8'h99, 8'h59, 8'h59, 8'h23, 8'h02, 8'h31, 8'h12, 8'h99, 8'h20});
        run_ticks(328);
        set_addr(4'd0);
        run_ticks(328);
        read_cont(NUM_REGS, got);
        check8("R10 snapshot hundredths", got[0], 8'h99);
        check8("R10 snapshot hours", got[3], 8'h23);
        check8("R10 snapshot year", got[7], 8'h99);
        check8("R10 snapshot century", got[8], 8'h20);
        check_frame("R10 fresh snapshot", '{8'h00, 8'h00, 8'h00, 8'h00, 8'h03, 8'h01, 8'h01, 8'h00, 8'h21});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_divider();
        t_idle_hold();
        t_write_timing();
        t_digit_carry();
        t_time_roll();
        t_month_len();
        t_leap();
        t_year();
        t_address();
        t_snapshot();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule